// File: doc/BRIEF.md
# Masked First-Set Mask Generator

This block computes the three vector mask scan results: set-before-first, set-including-first and set-only-first. It takes a source mask with one bit per element, an optional enable mask, the previous destination mask, a vector length, an operation select and a flag that turns masking on. Element 0 is the least significant bit, so "before" means a lower index.

The enable mask is applied to the source operand before the scan runs. A source bit at an inactive position cannot end the prefix. Active elements receive the scan value. Inactive elements and tail elements (index at or above the vector length) keep their previous destination bit.

A one-cycle `start` pulse latches the inputs. The new destination mask is registered and shown with a one-cycle `done` pulse on the next clock edge. The result then holds until the next start.

Top module: `mask_scan_unit`

## Requirements
- R1: With op = 0 (before-first), every active element below the lowest active element whose source bit is 1 is written 1, and every other active element is written 0.
- R2: With op = 1 (including-first), active elements below that position and the position itself are written 1, and active elements above it are written 0.
- R3: With op = 2 (only-first), only that position is written 1, and all other active elements are written 0.
- R4: The first set bit is searched among active elements only. A source bit of 1 at an inactive element has no effect on any result bit.
- R5: An inactive element below the vector length takes its bit from the old destination input.
- R6: If no active element has its source bit set, op 0 and op 1 write 1 to every active element, and op 2 writes 0 to every active element.
- R7: When mask_en is 0, every element below the vector length is active, whatever the enable mask holds.
- R8: Elements at index vl or above keep the old destination bit. With vl = 0 the whole result equals the old destination.
- R9: `done` is a single-cycle pulse on the clock edge after the one that samples `start`. `result` carries the new value in that same cycle.
- R10: Reset clears `result` to 0 and `done` to 0. Without a `start`, `result` holds its value even when the inputs change.
- R11: op = 3 is reserved. It writes the old destination unchanged to every element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle request; inputs are sampled on this edge |
| op | input | 2 | 0 before-first, 1 including-first, 2 only-first, 3 reserved |
| mask_en | input | 1 | 1 makes en_mask select the active elements |
| vl | input | $clog2(NE+1) | Vector length, from 0 to NE |
| src | input | NE | Source mask vector |
| en_mask | input | NE | Element enable mask |
| old_dst | input | NE | Previous destination mask |
| done | output | 1 | Result valid pulse |
| result | output | NE | Registered destination mask |

## Verification
The result and `done` both come out of a single register stage. They are therefore due on the first rising edge after the edge that sees `start` high. Each scenario task raises `start` at a falling edge and lowers it at the next falling edge. It checks `result` and `done` there, half a period after the producing edge. At the following falling edge it checks that `done` has dropped and that `result` has not moved, after first changing the source inputs. Expected masks come from a bench loop that walks the elements in index order and keeps a found flag.

// File: rtl/mask_scan_unit.sv
module mask_scan_unit #(
  parameter int NE = 64,
  localparam int VLW = $clog2(NE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     op,
  input  logic           mask_en,
  input  logic [VLW-1:0] vl,
  input  logic [NE-1:0]  src,
  input  logic [NE-1:0]  en_mask,
  input  logic [NE-1:0]  old_dst,
  output logic           done,
  output logic [NE-1:0]  result
);

  logic [NE-1:0] act, ms, incl, excl, scan, nxt;

  genvar g;
  for (g = 0; g < NE; g++) begin : g_el
    assign act[g] = (VLW'(g) < vl) && (!mask_en || en_mask[g]);
    if (g == 0) begin : g_first
      assign incl[g] = ms[g];
    end else begin : g_rest
      assign incl[g] = incl[g-1] | ms[g];
    end
  end

  assign ms   = src & act;
  assign excl = {incl[NE-2:0], 1'b0};

  always_comb begin
    case (op)
      2'd0:    scan = ~incl;
      2'd1:    scan = ~excl;
      2'd2:    scan = incl & ~excl;
      default: scan = old_dst;
    endcase
  end

  assign nxt = (act & scan) | (~act & old_dst);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= start;
      if (start) result <= nxt;
    end
  end

endmodule

// File: rtl/mask_scan_unit_chk.sv
module mask_scan_unit_chk #(
  parameter int NE = 64,
  localparam int VLW = $clog2(NE + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [1:0]     op,
  input logic           mask_en,
  input logic [VLW-1:0] vl,
  input logic [NE-1:0]  src,
  input logic [NE-1:0]  en_mask,
  input logic [NE-1:0]  old_dst,
  input logic           done,
  input logic [NE-1:0]  result
);

  logic [NE-1:0] live, tail;
  always_comb begin
    for (int i = 0; i < NE; i++) begin
      tail[i] = !(VLW'(i) < vl);
      live[i] = !tail[i] && (!mask_en || en_mask[i]);
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R9
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(start)); // R9
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(result)); // R10
  AST_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((result ^ $past(old_dst)) & ~$past(live)) == '0); // R5
  AST_SOF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd2) |=> $onehot0(result & $past(live))); // R3
  AST_RSVD_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd3) |=> result == $past(old_dst)); // R11
  AST_TAIL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((result ^ $past(old_dst)) & $past(tail)) == '0); // R8

endmodule

bind mask_scan_unit mask_scan_unit_chk #(.NE(NE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mask_en(mask_en), .vl(vl),
  .src(src), .en_mask(en_mask), .old_dst(old_dst), .done(done), .result(result)
);

// File: tb/test_mask_scan_unit.sv
module test_mask_scan_unit;
  localparam int NE = 16;
  localparam int VLW = $clog2(NE + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mask_en = 1'b0;
  logic [1:0] op = '0;
  logic [VLW-1:0] vl = '0;
  logic [NE-1:0] src = '0, en_mask = '0, old_dst = '0;
  logic done;
  logic [NE-1:0] result;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mask_scan_unit #(.NE(NE)) i_mask_scan_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mask_en(mask_en), .vl(vl),
    .src(src), .en_mask(en_mask), .old_dst(old_dst), .done(done), .result(result)
  );

  function automatic logic [NE-1:0] model(input logic [1:0] o, input logic me, input int l,
      input logic [NE-1:0] s, input logic [NE-1:0] e, input logic [NE-1:0] od);
    logic [NE-1:0] r = od;
    bit found = 0;
    if (o == 2'd3) return od;
    for (int i = 0; i < l; i++) begin
      if (me && !e[i]) continue;
      if (found) r[i] = 1'b0;
      else if (s[i]) begin found = 1; r[i] = (o != 2'd0); end
      else r[i] = (o != 2'd2);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [NE-1:0] act, input logic [NE-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] o, input logic me, input int l,
      input logic [NE-1:0] s, input logic [NE-1:0] e, input logic [NE-1:0] od);
    logic [NE-1:0] exp = model(o, me, l, s, e, od);
    @(negedge clk);
    op = o; mask_en = me; vl = VLW'(l); src = s; en_mask = e; old_dst = od; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " result"}, result, exp);
    check({req, " done pulse R9"}, {{(NE-1){1'b0}}, done}, 1);
    src = ~s; old_dst = ~od;
    @(negedge clk);
    check({req, " done low R9"}, {{(NE-1){1'b0}}, done}, 0);
    check({req, " hold R10"}, result, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 reset result", result, '0);
    check("R10 reset done", {{(NE-1){1'b0}}, done}, 0);
  endtask

  task automatic t_doc_case();
    run("R1 R4 masked before-first", 2'd0, 1'b1, 8, 16'h0094, 16'h00C3, 16'h0000);
    check("R1 value 0x43", result, 16'h0043);
  endtask

  task automatic t_ops();
    run("R1 before-first", 2'd0, 1'b0, 16, 16'h0120, 16'h0000, 16'hA5A5);
    check("R1 literal", result, 16'h001F);
    run("R2 including-first", 2'd1, 1'b0, 16, 16'h0120, 16'h0000, 16'hA5A5);
    check("R2 literal", result, 16'h003F);
    run("R3 only-first", 2'd2, 1'b0, 16, 16'h0120, 16'h0000, 16'hA5A5);
    check("R3 literal", result, 16'h0020);
    run("R3 R5 masked only-first", 2'd2, 1'b1, 12, 16'h0F0F, 16'h3CF0, 16'h5555);
    run("R2 R5 masked including-first", 2'd1, 1'b1, 16, 16'hF00A, 16'h0FF5, 16'hC003);
  endtask

  task automatic t_inactive_ignored();
    run("R4 inactive set bits ignored", 2'd1, 1'b1, 16, 16'h00FF, 16'hFF00, 16'h0000);
    check("R4 literal", result, 16'hFF00);
  endtask

  task automatic t_none_set();
    run("R6 sbf none", 2'd0, 1'b0, 16, 16'h0000, 16'h0000, 16'h0000);
    check("R6 sbf literal", result, 16'hFFFF);
    run("R6 sif none", 2'd1, 1'b1, 16, 16'h0F00, 16'h00F0, 16'h0000);
    check("R6 sif literal", result, 16'h00F0);
    run("R6 sof none", 2'd2, 1'b0, 16, 16'h0000, 16'h0000, 16'hFFFF);
    check("R6 sof literal", result, 16'h0000);
  endtask

  task automatic t_mask_off();
    run("R7 enable mask ignored", 2'd0, 1'b0, 16, 16'h0400, 16'h0001, 16'h0000);
    check("R7 literal", result, 16'h03FF);
  endtask

  task automatic t_tail();
    run("R8 tail kept", 2'd0, 1'b0, 5, 16'h0000, 16'h0000, 16'hAAAA);
    check("R8 literal", result, 16'hAABF);
    run("R8 vl zero", 2'd1, 1'b0, 0, 16'hFFFF, 16'hFFFF, 16'h1234);
    check("R8 vl0 literal", result, 16'h1234);
  endtask

  task automatic t_reserved();
    run("R11 reserved op", 2'd3, 1'b0, 16, 16'h0010, 16'hFFFF, 16'h6789);
    check("R11 literal", result, 16'h6789);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_doc_case();
    t_ops();
    t_inactive_ignored();
    t_none_set();
    t_mask_off();
    t_tail();
    t_reserved();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule